// File: doc/BRIEF.md
# Latching PHY Status Register Pair

This block holds the two status words that a PHY management interface reads. The primary word combines fixed capability flags with three event bits. The link bit latches low. The jabber bit latches high. The remote-fault bit latches high. A read of the primary word clears the jabber and remote-fault bits, and it re-arms the link bit. The primary word also shows the auto-negotiation-complete level as it is.

The secondary summary word carries copies of the link, jabber and remote-fault bits. Reading the summary word does not disturb these copies. Only a read of the primary word changes them. The summary word also holds a latch-high polarity-inversion bit, which clears on a read of the summary word or on a read of a second register elsewhere that owns the same bit. It also shows the auto-negotiation-complete level.

The management frame decoder supplies one-cycle read strobes, one for each register. Both words are presented continuously. The value seen during a strobe is the value before the clear, and the clear takes effect at the next clock edge.

Top module: `phy_stat_regs`

## Requirements
- R1: After reset, with every input low, the primary word reads 16'h7849 and the summary word reads 16'h0000.
- R2: Primary bits 14, 13, 12, 11, 6, 3 and 0 always read 1. Primary bits 15 and 10:7 always read 0. Summary bits 15:5 always read 0.
- R3: Primary bit 2 (link) clears one clock after any cycle with link_good_i low. When it is 0, it sets only on the clock after a cycle in which rd_main_i and link_good_i are both high.
- R4: Primary bit 1 (jabber) sets one clock after jabber_i is high. It then stays set until a primary read with jabber_i low, and it is 0 on the clock after that read.
- R5: Primary bit 4 (remote fault) sets one clock after rfault_i is high. It clears on the clock after a primary read with rfault_i low.
- R6: During a read strobe, the word shows the value held before the read. A clear or set caused by the read appears one clock later.
- R7: An event in the same cycle as a clearing read wins. For a latch-high bit, the bit stays set. For the link bit, a failure in the read cycle leaves it 0.
- R8: Summary bits 0 (link), 1 (jabber) and 2 (remote fault) always equal primary bits 2, 1 and 4. A summary read never changes them.
- R9: Summary bit 4 (polarity inverted) sets one clock after pol_inv_i is high. It clears on the clock after rd_summ_i or rd_polhome_i with pol_inv_i low. A primary read does not clear it.
- R10: Primary bit 5 and summary bit 3 follow an_done_i in the same cycle, without latching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| link_good_i | input | 1 | Live link-good level |
| jabber_i | input | 1 | Jabber event indication |
| rfault_i | input | 1 | Remote-fault event indication |
| an_done_i | input | 1 | Auto-negotiation-complete level |
| pol_inv_i | input | 1 | Inverted-polarity event indication |
| rd_main_i | input | 1 | One-cycle strobe: primary word is being read |
| rd_summ_i | input | 1 | One-cycle strobe: summary word is being read |
| rd_polhome_i | input | 1 | One-cycle strobe: the other register holding polarity is being read |
| main_word_o | output | 16 | Primary status word |
| summ_word_o | output | 16 | Summary status word |

## Verification
A wrong latch state shows on the next clock edge as one bit of a read word that differs from expectation. Both words are always visible, so no extra read is needed to expose it.

Three faults need reads placed with care, because each shows only one cycle after a strobe:
- a swapped clear source, such as a summary read clearing the jabber copy;
- an event lost to a simultaneous read;
- a link bit that re-arms without a read.

Checks sample the word during the strobe and again on the following cycle, so that both sides of the clear edge are covered.

// File: rtl/phy_stat_pkg.sv
package phy_stat_pkg;

  typedef enum logic {
    LATCH_HIGH = 1'b0,
    LATCH_LOW  = 1'b1
  } latch_kind_e;

  // Bit positions in the primary word (fixed by the management map)
  localparam int unsigned PRI_JAB  = 1;
  localparam int unsigned PRI_LINK = 2;
  localparam int unsigned PRI_RF   = 4;
  localparam int unsigned PRI_AN   = 5;

  // Bit positions in the summary word
  localparam int unsigned SUM_LINK = 0;
  localparam int unsigned SUM_JAB  = 1;
  localparam int unsigned SUM_RF   = 2;
  localparam int unsigned SUM_AN   = 3;
  localparam int unsigned SUM_POL  = 4;

  // Latch slot indices
  localparam int unsigned SLOT_LINK = 0;
  localparam int unsigned SLOT_JAB  = 1;
  localparam int unsigned SLOT_RF   = 2;
  localparam int unsigned SLOT_POL  = 3;
  localparam int unsigned NUM_SLOTS = 4;

  typedef struct packed {
    logic pol;
    logic rf;
    logic jab;
    logic link;
  } stat_bits_t;

endpackage

// File: rtl/phy_stat_latch.sv
module phy_stat_latch
  import phy_stat_pkg::*;
#(
  parameter latch_kind_e KIND = LATCH_HIGH
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cond_i,   // event (latch-high) or good level (latch-low)
  input  logic clr_i,    // clearing / re-arming read
  output logic q_o
);

  logic q_r;
  logic q_d;
  logic q_en;

  generate
    if (KIND == LATCH_HIGH) begin : g_hi
      always_comb begin
        q_d = cond_i | (q_r & ~clr_i);
      end
    end else begin : g_lo
      always_comb begin
        q_d = cond_i & (q_r | clr_i);
      end
    end
  endgenerate

  always_comb begin
    q_en = (q_d != q_r);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= 1'b0;
    end else if (q_en) begin
      q_r <= q_d;
    end
  end

  assign q_o = q_r;

  generate
    if (KIND == LATCH_HIGH) begin : g_hi_chk
      // R7
      event_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cond_i |=> q_o);
      // R4
      read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !cond_i) |=> !q_o);
      // R6
      sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_o && !clr_i) |=> q_o);
    end else begin : g_lo_chk
      // R3
      fail_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cond_i |=> !q_o);
      // R3
      no_self_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!q_o && !clr_i) |=> !q_o);
      // R6
      rearm_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_i && clr_i) |=> q_o);
    end
  endgenerate

endmodule

// File: rtl/phy_stat_pack.sv
module phy_stat_pack
  import phy_stat_pkg::*;
#(
  parameter int unsigned      WORD_W   = 16,
  parameter logic [WORD_W-1:0] CAP_WORD = 16'h7849
) (
  input  stat_bits_t        bits_i,
  input  logic              an_done_i,
  output logic [WORD_W-1:0] main_o,
  output logic [WORD_W-1:0] summ_o
);

  always_comb begin
    main_o           = CAP_WORD;
    main_o[PRI_LINK] = bits_i.link;
    main_o[PRI_JAB]  = bits_i.jab;
    main_o[PRI_RF]   = bits_i.rf;
    main_o[PRI_AN]   = an_done_i;
  end

  always_comb begin
    summ_o          = '0;
    summ_o[SUM_LINK] = bits_i.link;
    summ_o[SUM_JAB]  = bits_i.jab;
    summ_o[SUM_RF]   = bits_i.rf;
    summ_o[SUM_AN]   = an_done_i;
    summ_o[SUM_POL]  = bits_i.pol;
  end

endmodule

// File: rtl/phy_stat_regs.sv
module phy_stat_regs
  import phy_stat_pkg::*;
#(
  parameter int unsigned       WORD_W      = 16,
  parameter logic [WORD_W-1:0] CAP_WORD    = 16'h7849,
  parameter int unsigned       SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_good_i,
  input  logic              jabber_i,
  input  logic              rfault_i,
  input  logic              an_done_i,
  input  logic              pol_inv_i,
  input  logic              rd_main_i,
  input  logic              rd_summ_i,
  input  logic              rd_polhome_i,
  output logic [WORD_W-1:0] main_word_o,
  output logic [WORD_W-1:0] summ_word_o
);

  localparam int unsigned SYNC_LAST = SYNC_STAGES - 1;

  // Reset: asserted asynchronously, released through a flop chain
  logic [SYNC_LAST:0] rst_sync_r;
  logic               rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_r <= '0;
    end else begin
      rst_sync_r <= {rst_sync_r[SYNC_LAST:0], 1'b1} >> 1 | {1'b0, rst_sync_r[SYNC_LAST:0]} << 1 | {{SYNC_LAST{1'b0}}, 1'b1};
    end
  end

  assign rst_int_n = rst_sync_r[SYNC_LAST];

  // Condition and clear sources per latch slot
  logic [NUM_SLOTS-1:0] slot_cond;
  logic [NUM_SLOTS-1:0] slot_clr;
  logic [NUM_SLOTS-1:0] slot_q;

  always_comb begin
    slot_cond            = '0;
    slot_clr             = '0;
    slot_cond[SLOT_LINK] = link_good_i;
    slot_clr[SLOT_LINK]  = rd_main_i;
    slot_cond[SLOT_JAB]  = jabber_i;
    slot_clr[SLOT_JAB]   = rd_main_i;
    slot_cond[SLOT_RF]   = rfault_i;
    slot_clr[SLOT_RF]    = rd_main_i;
    slot_cond[SLOT_POL]  = pol_inv_i;
    slot_clr[SLOT_POL]   = rd_summ_i | rd_polhome_i;
  end

  generate
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      localparam latch_kind_e SLOT_KIND = (s == SLOT_LINK) ? LATCH_LOW : LATCH_HIGH;
      phy_stat_latch #(
        .KIND(SLOT_KIND)
      ) u_latch (
        .clk    (clk),
        .rst_n  (rst_int_n),
        .cond_i (slot_cond[s]),
        .clr_i  (slot_clr[s]),
        .q_o    (slot_q[s])
      );
    end
  endgenerate

  stat_bits_t bits;

  always_comb begin
    bits.link = slot_q[SLOT_LINK];
    bits.jab  = slot_q[SLOT_JAB];
    bits.rf   = slot_q[SLOT_RF];
    bits.pol  = slot_q[SLOT_POL];
  end

  phy_stat_pack #(
    .WORD_W   (WORD_W),
    .CAP_WORD (CAP_WORD)
  ) u_pack (
    .bits_i    (bits),
    .an_done_i (an_done_i),
    .main_o    (main_word_o),
    .summ_o    (summ_word_o)
  );

  // R9
  pol_either_read_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((rd_summ_i || rd_polhome_i) && !pol_inv_i) |=> !summ_word_o[SUM_POL]);
  // R9
  pol_main_read_keeps_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (summ_word_o[SUM_POL] && rd_main_i && !rd_summ_i && !rd_polhome_i) |=> summ_word_o[SUM_POL]);
  // R8
  summ_read_keeps_jab_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rd_summ_i && !rd_main_i && main_word_o[PRI_JAB]) |=> summ_word_o[SUM_JAB]);
  // R8
  summ_read_keeps_rf_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rd_summ_i && !rd_main_i && main_word_o[PRI_RF]) |=> summ_word_o[SUM_RF]);

endmodule

// File: tb/phy_stat_regs_test.sv
module phy_stat_regs_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        link_good, jabber, rfault, an_done, pol_inv;
  logic        rd_main, rd_summ, rd_polhome;
  logic [15:0] main_word, summ_word;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  phy_stat_regs uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .link_good_i  (link_good),
    .jabber_i     (jabber),
    .rfault_i     (rfault),
    .an_done_i    (an_done),
    .pol_inv_i    (pol_inv),
    .rd_main_i    (rd_main),
    .rd_summ_i    (rd_summ),
    .rd_polhome_i (rd_polhome),
    .main_word_o  (main_word),
    .summ_word_o  (summ_word)
  );

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [15:0] em, input logic [15:0] es);
    #1;
    checks++;
    if (main_word !== em || summ_word !== es) begin
      errors++;
      $display("FAIL %s: main=%h summ=%h expected main=%h summ=%h",
               tag, main_word, summ_word, em, es);
    end
  endtask

  task automatic t_reset;
    chk("R1 reset words", 16'h7849, 16'h0000);
    tick;
    chk("R2 idle constants", 16'h7849, 16'h0000);
  endtask

  task automatic t_link;
    link_good = 1; tick;
    chk("R3 no set without read", 16'h7849, 16'h0000);
    rd_main = 1;
    chk("R6 pre-read link value", 16'h7849, 16'h0000);
    tick; rd_main = 0;
    chk("R3 set after read", 16'h784D, 16'h0001);
    rd_summ = 1; tick; rd_summ = 0;
    chk("R8 summary read keeps link", 16'h784D, 16'h0001);
    link_good = 0; tick;
    chk("R3 failure clears", 16'h7849, 16'h0000);
    link_good = 1; tick; tick;
    chk("R3 stays low while good", 16'h7849, 16'h0000);
    link_good = 0; rd_main = 1; tick;
    chk("R7 failure in read cycle", 16'h7849, 16'h0000);
    link_good = 1; tick; rd_main = 0;
    chk("R3 rearm read", 16'h784D, 16'h0001);
    link_good = 0; tick;
    chk("R3 drop again", 16'h7849, 16'h0000);
  endtask

  task automatic t_jabber;
    jabber = 1; tick; jabber = 0;
    chk("R4 jabber set", 16'h784B, 16'h0002);
    rd_summ = 1; tick; rd_summ = 0;
    chk("R8 summary read keeps jabber", 16'h784B, 16'h0002);
    rd_main = 1;
    chk("R6 jabber seen during read", 16'h784B, 16'h0002);
    tick; rd_main = 0;
    chk("R4 jabber cleared by primary read", 16'h7849, 16'h0000);
  endtask

  task automatic t_collide;
    jabber = 1; tick;
    rd_main = 1; tick;
    chk("R7 jabber kept on same-cycle read", 16'h784B, 16'h0002);
    jabber = 0; tick; rd_main = 0;
    chk("R4 jabber cleared after event ends", 16'h7849, 16'h0000);
  endtask

  task automatic t_rfault;
    rfault = 1; tick; rfault = 0;
    chk("R5 remote fault set", 16'h7859, 16'h0004);
    rd_summ = 1; tick; rd_summ = 0;
    chk("R8 summary read keeps remote fault", 16'h7859, 16'h0004);
    tick;
    chk("R5 remote fault sticky", 16'h7859, 16'h0004);
    rd_main = 1; tick; rd_main = 0;
    chk("R5 remote fault cleared with copy", 16'h7849, 16'h0000);
  endtask

  task automatic t_pol;
    pol_inv = 1; tick; pol_inv = 0;
    chk("R9 polarity set", 16'h7849, 16'h0010);
    rd_main = 1; tick; rd_main = 0;
    chk("R9 primary read keeps polarity", 16'h7849, 16'h0010);
    rd_summ = 1;
    chk("R6 polarity seen during read", 16'h7849, 16'h0010);
    tick; rd_summ = 0;
    chk("R9 summary read clears polarity", 16'h7849, 16'h0000);
    pol_inv = 1; tick; pol_inv = 0;
    rd_polhome = 1; tick; rd_polhome = 0;
    chk("R9 home read clears polarity", 16'h7849, 16'h0000);
    pol_inv = 1; rd_summ = 1; tick; pol_inv = 0;
    chk("R7 polarity kept on same-cycle read", 16'h7849, 16'h0010);
    tick; rd_summ = 0;
    chk("R9 polarity cleared later", 16'h7849, 16'h0000);
  endtask

  task automatic t_an;
    an_done = 1;
    chk("R10 an level shown at once", 16'h7869, 16'h0008);
    jabber = 1; tick; jabber = 0;
    chk("R10 an with jabber", 16'h786B, 16'h000A);
    rd_main = 1; tick; rd_main = 0;
    an_done = 0;
    chk("R10 an dropped", 16'h7849, 16'h0000);
  endtask

  initial begin
    rst_n = 0; link_good = 0; jabber = 0; rfault = 0; an_done = 0;
    pol_inv = 0; rd_main = 0; rd_summ = 0; rd_polhome = 0;
    repeat (3) tick;
    rst_n = 1;
    repeat (4) tick;
    t_reset;
    t_link;
    t_jabber;
    t_collide;
    t_rfault;
    t_pol;
    t_an;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule